// File: doc/BRIEF.md
# Serial Framed Packet Transmitter

This block is the output side of one router port. It takes payload bytes from a byte-wide valid/ready handshake, each byte tagged with an end-of-packet flag. It sends them on a single serial data line together with two active-low qualifiers: a packet frame and a bit-valid strobe. The receiving side counts a data bit only on clocks where the valid strobe is low. Any clock with the strobe high is a gap that carries no data.

A packet opens with the frame dropping one clock before its first data bit. Each byte follows, least significant bit first. The frame rises again on the very clock that carries the final bit of the byte flagged as last. If the next byte of an open packet is late, the line stalls with frame low and valid high until the byte arrives. When bytes keep arriving in time, consecutive bytes run back to back with no gap. After every packet the line rests for at least one fully idle clock. The block is used to drive a receiver model and to confirm that bytes come out in the order they were accepted.

Top module: `serial_packet_tx`

## Requirements
- R1: The frame output goes low at least one clock before the first data bit of a packet. On the clock just before that first bit, frame is low and valid is high.
- R2: Bytes leave the serial line in exactly the order they were accepted. A data bit never appears unless an accepted byte is still waiting to be sent.
- R3: Each byte is sent as DATA_W (default 8) data bits, bit 0 first. A bit is carried on the data line only on clocks where the valid output is low.
- R4: While a packet is open, the frame output is high on a data-bit clock only when that clock carries the final bit of the byte flagged as last. On that clock the frame rises.
- R5: When an open packet has no next byte available, valid stays high and frame stays low. No partial byte is left pending and the bit count does not advance.
- R6: An asynchronous active-low reset immediately forces the data line to 0, frame high and valid high. This holds also when reset is applied in the middle of a packet.
- R7: After the frame rises, frame and valid both stay high for at least GAP_MIN (default 1) clocks before the frame falls again.
- R8: A byte is taken on a rising clock edge where the input valid and the input ready are both high. Ready is high only when the shifter is empty, or when it is emitting the final bit of a byte that is not flagged as last.
- R9: A packet made of one byte flagged as last still carries a full 8 data bits. Frame stays low until the eighth bit.
- R10: When the next byte is offered in time, the bytes of one packet follow each other with no gap clock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Payload byte offered to the transmitter |
| in_last | input | 1 | Marks the offered byte as the final byte of its packet |
| in_valid | input | 1 | Offered byte and flag are valid |
| in_ready | output | 1 | Transmitter takes the byte on this edge when in_valid is high |
| ser_data | output | 1 | Serial data bit |
| ser_frame_n | output | 1 | Packet frame, low while a packet is open |
| ser_valid_n | output | 1 | Bit strobe, low on clocks that carry a data bit |

## Verification
Stimulus mixes directed packets with random ones. The directed cases are a single-byte packet, a packet whose bytes are offered without pause, and a packet with a long stall between two bytes. The random packets are 1 to 6 bytes long with random payload and random input stalls of varying length. The single-byte case shows that closing the frame on the eighth bit works when no earlier byte exists. The unbroken case tells zero-gap chaining apart from the stall case, where gap clocks must appear but only on byte boundaries. The random traffic exercises ordering, the ready rule and the idle clock between packets under every mix of early and late bytes. A reset applied in the middle of a packet checks that the line returns to idle at once, without waiting for a clock edge.

// File: rtl/sptx_pkg.sv
`timescale 1ns/100ps
package sptx_pkg;

   // one clock worth of serial line state
   typedef struct packed {
      logic data;
      logic frame_n;
      logic valid_n;
   } sptx_line_t;

   localparam sptx_line_t LINE_IDLE = '{data: 1'b0, frame_n: 1'b1, valid_n: 1'b1};

   // width needed to hold values 0..n
   function automatic int unsigned count_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sptx_shifter.sv
`timescale 1ns/100ps
module sptx_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter int unsigned CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_last,
   output logic              bit_out,
   output logic [CNT_W-1:0]  bits_left,
   output logic              last_q
);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign bit_out    = shreg[0];
         assign shreg_next = {1'b0, shreg[DATA_W-1:1]};
      end else begin : g_msb
         assign bit_out    = shreg[DATA_W-1];
         assign shreg_next = {shreg[DATA_W-2:0], 1'b0};
      end
   endgenerate

   // a load on the final-bit clock overrides the shift: that bit is
   // already on bit_out and gets registered by the framer this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= '0;
         last_q    <= 1'b0;
      end else if (load) begin
         shreg     <= load_data;
         bits_left <= CNT_W'(DATA_W);
         last_q    <= load_last;
      end else if (bits_left != '0) begin
         shreg     <= shreg_next;
         bits_left <= bits_left - 1'b1;
      end
   end

endmodule

// File: rtl/sptx_gap_timer.sv
`timescale 1ns/100ps
module sptx_gap_timer #(
   parameter int unsigned GAP_MIN = 1,
   parameter int unsigned GAP_W   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   logic [GAP_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start) begin
         remain <= GAP_W'(GAP_MIN);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/sptx_framer.sv
`timescale 1ns/100ps
module sptx_framer
   import sptx_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] bits_left,
   input  logic             last_q,
   input  logic             bit_out,
   input  logic             in_valid,
   input  logic             gap_busy,
   output logic             in_ready,
   output logic             load,
   output logic             gap_start,
   output sptx_line_t       line
);

   logic in_pkt;
   logic final_bit;
   logic closing;
   logic empty;

   assign empty     = (bits_left == '0);
   assign final_bit = (bits_left == CNT_W'(1));
   assign closing   = final_bit & last_q;
   assign in_ready  = !gap_busy & (empty | (final_bit & !last_q));
   assign load      = in_valid & in_ready;
   assign gap_start = closing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line   <= LINE_IDLE;
         in_pkt <= 1'b0;
      end else if (!empty) begin
         line <= '{data: bit_out, frame_n: closing, valid_n: 1'b0};
         if (closing) begin
            in_pkt <= 1'b0;
         end
      end else begin
         // empty shifter: announce clock, stall clock or idle clock
         line <= '{data: 1'b0, frame_n: !(in_pkt | load), valid_n: 1'b1};
         if (load) begin
            in_pkt <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/serial_packet_tx.sv
`timescale 1ns/100ps
module serial_packet_tx
   import sptx_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned GAP_MIN   = 1,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              ser_data,
   output logic              ser_frame_n,
   output logic              ser_valid_n
);

   localparam int unsigned CNT_W = count_width(DATA_W);
   localparam int unsigned GAP_W = count_width(GAP_MIN);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_packet_tx: DATA_W must be at least 2");
      end
      if (GAP_MIN < 1) begin : g_bad_gap
         $error("serial_packet_tx: GAP_MIN must be at least 1");
      end
   endgenerate

   logic             load;
   logic             gap_start;
   logic             gap_busy;
   logic             bit_out;
   logic             last_q;
   logic [CNT_W-1:0] bits_left;
   sptx_line_t       line;

   sptx_shifter #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST),
      .CNT_W     (CNT_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (in_data),
      .load_last (in_last),
      .bit_out   (bit_out),
      .bits_left (bits_left),
      .last_q    (last_q)
   );

   sptx_gap_timer #(
      .GAP_MIN (GAP_MIN),
      .GAP_W   (GAP_W)
   ) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gap_start),
      .busy  (gap_busy)
   );

   sptx_framer #(
      .CNT_W (CNT_W)
   ) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bits_left (bits_left),
      .last_q    (last_q),
      .bit_out   (bit_out),
      .in_valid  (in_valid),
      .gap_busy  (gap_busy),
      .in_ready  (in_ready),
      .load      (load),
      .gap_start (gap_start),
      .line      (line)
   );

   assign ser_data    = line.data;
   assign ser_frame_n = line.frame_n;
   assign ser_valid_n = line.valid_n;

endmodule

// File: rtl/sptx_checker.sv
`timescale 1ns/100ps
module sptx_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic frame_n,
   input logic valid_n
);

   localparam int unsigned BC_W = $clog2(DATA_W);

   logic [BC_W-1:0] bit_phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_phase <= '0;
      end else if (!valid_n) begin
         bit_phase <= (bit_phase == BC_W'(DATA_W - 1)) ? '0 : bit_phase + 1'b1;
      end
   end

   // R1
   frame_open_before_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_n |-> !$past(frame_n));

   // R4
   frame_close_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n && !valid_n) |-> $rose(frame_n));

   // R3
   close_on_byte_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_n) |-> (bit_phase == BC_W'(DATA_W - 1)));

   // R7
   idle_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_n) |=> (frame_n && valid_n));

endmodule

bind serial_packet_tx sptx_checker #(.DATA_W(DATA_W)) u_sptx_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_n (ser_frame_n),
   .valid_n (ser_valid_n)
);

// File: tb/serial_packet_tx_test.sv
`timescale 1ns/100ps
module serial_packet_tx_test;

   localparam int GAP = 1;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] in_data;
   logic       in_last;
   logic       in_valid;
   logic       in_ready;
   logic       ser_data;
   logic       ser_frame_n;
   logic       ser_valid_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   serial_packet_tx #(.DATA_W(8), .GAP_MIN(GAP), .LSB_FIRST(1'b1)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .ser_data    (ser_data),
      .ser_frame_n (ser_frame_n),
      .ser_valid_n (ser_valid_n)
   );

   // expected bytes: {last, data}
   logic [8:0] pend[$];
   bit         mon_en = 1'b0;
   int         bitpos = 0;
   int         pkt_bytes = 0;
   int         pkt_bits = 0;
   int         mid_gaps = 0;
   int         idle_run = 0;
   bit         seen_close = 1'b0;
   logic       prev_f = 1'b1;
   logic       prev_v = 1'b1;
   logic [7:0] acc = '0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // receiver model, samples away from the rising edge
   always @(negedge clk) begin
      if (mon_en) begin
         if (!ser_valid_n) begin
            if (pend.size() == 0) begin
               check(1'b0, "R2 bit with nothing pending", 1, 0);
            end else begin
               if (bitpos == 0 && pkt_bytes == 0)
                  check(prev_f == 1'b0 && prev_v == 1'b1, "R1 frame before first bit",
                        {prev_f, prev_v}, 1);
               check(ser_frame_n == ((bitpos == 7) && pend[0][8]), "R4 frame on data bit",
                     ser_frame_n, (bitpos == 7) && pend[0][8]);
               acc[bitpos] = ser_data;
               bitpos++;
               pkt_bits++;
               if (bitpos == 8) begin
                  check(acc == pend[0][7:0], "R2 R3 byte value/order", acc, pend[0][7:0]);
                  void'(pend.pop_front());
                  bitpos = 0;
                  pkt_bytes++;
               end
               if (ser_frame_n) begin
                  if (pkt_bytes == 1)
                     check(pkt_bits == 8, "R9 single-byte bit count", pkt_bits, 8);
                  else
                     check(pkt_bits == 8 * pkt_bytes, "R3 packet bit count", pkt_bits, 8 * pkt_bytes);
                  pkt_bytes  = 0;
                  pkt_bits   = 0;
                  seen_close = 1'b1;
                  idle_run   = 0;
               end
            end
         end else if (!ser_frame_n) begin
            if (prev_f && seen_close)
               check(idle_run >= GAP, "R7 idle clocks between packets", idle_run, GAP);
            if (pkt_bytes > 0 || bitpos != 0) begin
               check(bitpos == 0, "R5 gap only on byte boundary", bitpos, 0);
               mid_gaps++;
            end
         end else begin
            idle_run++;
         end
         prev_f = ser_frame_n;
         prev_v = ser_valid_n;
      end
   end

   task automatic send_byte(input logic [7:0] d, input bit last, input int stall);
      bit taken = 1'b0;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         #0.5;
         in_valid = 1'b0;
      end
      while (!taken) begin
         @(negedge clk);
         #0.5;
         in_valid = 1'b1;
         in_data  = d;
         in_last  = last;
         if (in_ready) begin
            // R8: ready only with empty shifter or final bit of a non-last byte
            check((pend.size() == 0) || (pend.size() == 1 && bitpos == 7 && !pend[0][8]),
                  "R8 ready rule", pend.size() * 10 + bitpos, 0);
            pend.push_back({last, d});
            taken = 1'b1;
         end
      end
   endtask

   task automatic end_pkt();
      @(negedge clk);
      #0.5;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while ((pend.size() != 0 || !ser_frame_n || !ser_valid_n) && n < 400) begin
         @(negedge clk);
         n++;
      end
      #0.5;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int m0;
      void'($urandom(32'h5A17));
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      in_last  = 1'b0;
      repeat (2) @(negedge clk);
      // R6 reset state
      check(ser_data == 1'b0, "R6 reset data", ser_data, 0);
      check(ser_frame_n == 1'b1, "R6 reset frame", ser_frame_n, 1);
      check(ser_valid_n == 1'b1, "R6 reset valid", ser_valid_n, 1);
      #0.5;
      rst_n  = 1'b1;
      mon_en = 1'b1;

      // R9 single byte packet
      send_byte(8'hA5, 1'b1, 0);
      end_pkt();
      drain();

      // R10 bytes offered without pause
      m0 = mid_gaps;
      send_byte(8'h01, 1'b0, 0);
      send_byte(8'h80, 1'b0, 0);
      send_byte(8'hFF, 1'b1, 0);
      end_pkt();
      drain();
      check(mid_gaps == m0, "R10 no gap when bytes are ready", mid_gaps - m0, 0);

      // R5 long stall between two bytes
      m0 = mid_gaps;
      send_byte(8'h3C, 1'b0, 0);
      send_byte(8'hC3, 1'b1, 16);
      end_pkt();
      drain();
      check(mid_gaps - m0 >= 4, "R5 stall clocks inside packet", mid_gaps - m0, 4);

      // random traffic
      for (int p = 0; p < 40; p++) begin
         int len = 1 + ($urandom % 6);
         for (int b = 0; b < len; b++) begin
            int st = (($urandom % 4) == 0) ? ($urandom % 12) : 0;
            send_byte(8'($urandom), (b == len - 1), st);
         end
         end_pkt();
         if (($urandom % 3) == 0) repeat ($urandom % 5) @(negedge clk);
      end
      drain();
      check(pend.size() == 0, "R2 all accepted bytes delivered", pend.size(), 0);

      // R6 asynchronous reset in the middle of a packet
      send_byte(8'h5A, 1'b0, 0);
      end_pkt();
      repeat (4) @(negedge clk);
      #0.5;
      mon_en = 1'b0;
      rst_n  = 1'b0;
      #0.5;
      check(ser_data == 1'b0, "R6 mid-packet reset data", ser_data, 0);
      check(ser_frame_n == 1'b1, "R6 mid-packet reset frame", ser_frame_n, 1);
      check(ser_valid_n == 1'b1, "R6 mid-packet reset valid", ser_valid_n, 1);
      @(negedge clk);
      check(ser_frame_n == 1'b1 && ser_valid_n == 1'b1, "R6 held in reset",
            {ser_frame_n, ser_valid_n}, 3);
      finish_run();
   end

endmodule